// File: doc/BRIEF.md
# Battery Power Mode Controller

This block selects the operating mode of a battery-powered power-management device and drives the enables that follow from it. There are three modes: low-power, active-battery and charger. Comparator flags, a low-power request pin, an active-low pushbutton and an overcurrent flag arrive asynchronously. Each passes through a two-flop synchronizer before the mode logic sees it. A pending-transaction flag, a battery voltage code, a programmable battery threshold, a hardware-reset start pulse and a power-up-complete pulse are synchronous to the block clock.

The controller registers one mode per cycle. From that mode it drives the clock gate, the serial bus enable, the ADC enable and the battery discharge switch enable, each from its own flop. Battery health comes from a comparator with a programmable trip level and a fixed rise margin of 150 mV, expressed in code steps of the battery voltage LSB.

Top module: `pmic_mode_ctrl`

## Requirements
- R1: From active-battery mode, low-power mode is entered only when all of these hold at once: the low-power pin is low, the input-valid flag is low, the pushbutton is high and the busy flag is low. While busy is high the mode stays active-battery.
- R2: Low-power mode is left as soon as the low-power pin goes high (to active-battery) or the input-valid flag goes high (to charger).
- R3: In low-power mode the clock enable, bus enable and ADC enable are all 0. In active-battery and charger modes the clock enable and bus enable are 1.
- R4: While the overvoltage flag is high the mode is active-battery, whatever the low-power pin and input-valid flag are.
- R5: The pushbutton held low forces active-battery mode. Releasing it returns to low-power mode when the other conditions of R1 still hold.
- R6: A hardware-reset start pulse that arrives while the low-power pin is low keeps the block out of low-power mode until a power-up-complete pulse arrives. A start pulse that arrives while the pin is high has no effect.
- R7: The discharge enable is 1 only when the mode is not charger, the battery is judged healthy and the overcurrent flag is low.
- R8: The battery is judged unhealthy once its code is below the threshold code. It is judged healthy again only once the code is at or above the threshold plus 15 codes (150 mV at a 10 mV LSB). Codes in between keep the previous judgement.
- R9: Charger mode (code 2'b10) is entered whenever the input-valid flag is high and the overvoltage flag is low. The ADC enable is 1 in charger mode and 0 in the other two modes.
- R10: Mode codes are 2'b00 low-power, 2'b01 active-battery, 2'b10 charger. During reset the mode is active-battery with the clock and bus enables 1, and the ADC and discharge enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_ok_a | input | 1 | Input above undervoltage level (async) |
| vin_ov_a | input | 1 | Input above overvoltage level (async) |
| lp_pin_a | input | 1 | Low-power request pin, low requests low-power (async) |
| btn_n_a | input | 1 | Pushbutton, active low (async) |
| ocp_a | input | 1 | Battery overcurrent flag (async) |
| bus_busy | input | 1 | Serial transaction or interrupt still pending |
| hwrst_start | input | 1 | One-cycle pulse: long-press hardware reset began |
| pwrup_done | input | 1 | One-cycle pulse: power-up sequence complete |
| bat_code | input | BAT_W | Battery voltage code |
| bat_thr | input | BAT_W | Programmed battery undervoltage threshold code |
| mode_o | output | 2 | Current mode code |
| clk_en_o | output | 1 | Internal clock enable |
| bus_en_o | output | 1 | Serial bus interface enable |
| adc_en_o | output | 1 | ADC continuous-conversion enable |
| dsg_en_o | output | 1 | Battery discharge switch enable |

## Verification
The assertions assume that the synchronous inputs stay steady around the clock edge. They also assume that the battery code and threshold sit inside the code range, so that the threshold plus the rise margin does not wrap. The bench drives every input on the falling edge and holds each pattern for several cycles. It keeps the threshold far from full scale and sends the reset-start and power-up pulses one cycle wide. Async pins change only between checks, so the synchronizer delay never splits one pattern across two states.

// File: rtl/pmic_mode_pkg.sv
package pmic_mode_pkg;

    typedef enum logic [1:0] {
        MODE_LP  = 2'b00,
        MODE_ACT = 2'b01,
        MODE_CHG = 2'b10
    } pwr_mode_e;

    // asynchronous pins after synchronization
    typedef struct packed {
        logic vin_ok;
        logic vin_ov;
        logic lp_pin;
        logic btn_n;
        logic ocp;
    } pin_bus_t;

    localparam int PIN_COUNT = $bits(pin_bus_t);

    // safe values before the synchronizers fill: no input, no LP request, button released
    localparam pin_bus_t PIN_RST = '{vin_ok: 1'b0, vin_ov: 1'b0, lp_pin: 1'b1,
                                     btn_n: 1'b1, ocp: 1'b0};

    typedef struct packed {
        logic clk_en;
        logic bus_en;
        logic adc_en;
        logic dsg_en;
    } pwr_en_t;

    localparam pwr_en_t EN_RST = '{clk_en: 1'b1, bus_en: 1'b1, adc_en: 1'b0, dsg_en: 1'b0};

    function automatic int hyst_codes(input int mv, input int lsb_mv);
        return (mv + lsb_mv - 1) / lsb_mv;
    endfunction

    function automatic pwr_en_t enables_for(input pwr_mode_e m, input logic bat_ok,
                                            input logic ocp);
        pwr_en_t e;
        e.clk_en = (m != MODE_LP);
        e.bus_en = (m != MODE_LP);
        e.adc_en = (m == MODE_CHG);
        e.dsg_en = (m != MODE_CHG) && bat_ok && !ocp;
        return e;
    endfunction

endpackage

// File: rtl/pmic_sync.sv
module pmic_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d_a;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pmic_bat_uv.sv
module pmic_bat_uv #(
    parameter int W    = 10,
    parameter int HYST = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code,
    input  logic [W-1:0] thr,
    output logic         bat_ok
);
    localparam int WX = W + 1;

    logic [WX-1:0] rise_lvl;
    logic          below_trip;
    logic          above_rise;

    assign rise_lvl   = {1'b0, thr} + WX'(HYST);
    assign below_trip = (code < thr);
    assign above_rise = ({1'b0, code} >= rise_lvl);

    always_ff @(posedge clk) begin
        if (rst)                    bat_ok <= 1'b0;
        else if (bat_ok && below_trip) bat_ok <= 1'b0;
        else if (!bat_ok && above_rise) bat_ok <= 1'b1;
    end

    // R8: inside the band the judgement is held
    p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!bat_ok && ({1'b0, code} < ({1'b0, thr} + WX'(HYST)))) |=> !bat_ok);
    p_hold_high_r8: assert property (@(posedge clk) disable iff (rst)
        (bat_ok && (code >= thr)) |=> bat_ok);
endmodule

// File: rtl/pmic_mode_fsm.sv
module pmic_mode_fsm
    import pmic_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_bus_t  pins,
    input  logic      busy,
    input  logic      hwrst_start,
    input  logic      pwrup_done,
    input  logic      bat_ok,
    output pwr_mode_e mode,
    output pwr_en_t   en
);
    pwr_mode_e mode_nxt;
    logic      rst_hold;
    logic      lp_ok;

    // power-up hold latch: set beats clear
    always_ff @(posedge clk) begin
        if (rst)                            rst_hold <= 1'b0;
        else if (hwrst_start && !pins.lp_pin) rst_hold <= 1'b1;
        else if (pwrup_done)                rst_hold <= 1'b0;
    end

    // entry needs an idle bus, staying does not
    always_comb begin
        lp_ok = !pins.lp_pin && !pins.vin_ok && pins.btn_n && !rst_hold &&
                ((mode == MODE_LP) || !busy);
    end

    always_comb begin
        if (pins.vin_ov)      mode_nxt = MODE_ACT;
        else if (pins.vin_ok) mode_nxt = MODE_CHG;
        else if (lp_ok)       mode_nxt = MODE_LP;
        else                  mode_nxt = MODE_ACT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_ACT;
            en   <= EN_RST;
        end else begin
            mode <= mode_nxt;
            en   <= enables_for(mode_nxt, bat_ok, pins.ocp);
        end
    end

    p_busy_blocks_entry_r1: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_LP && busy) |=> mode != MODE_LP);
    p_lp_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LP && (pins.lp_pin || pins.vin_ok)) |=> mode != MODE_LP);
    p_lp_gated_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LP) |-> (!en.clk_en && !en.bus_en && !en.adc_en));
    p_ov_active_r4: assert property (@(posedge clk) disable iff (rst)
        pins.vin_ov |=> mode == MODE_ACT);
    p_button_r5: assert property (@(posedge clk) disable iff (rst)
        !pins.btn_n |=> mode != MODE_LP);
    p_reset_hold_r6: assert property (@(posedge clk) disable iff (rst)
        rst_hold |=> mode != MODE_LP);
    p_ocp_off_r7: assert property (@(posedge clk) disable iff (rst)
        pins.ocp |=> !en.dsg_en);
    p_chg_adc_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHG) |-> (en.adc_en && !en.dsg_en));
    p_legal_code_r10: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

// File: rtl/pmic_mode_ctrl.sv
module pmic_mode_ctrl #(
    parameter int BAT_W   = 10,
    parameter int LSB_MV  = 10,
    parameter int HYST_MV = 150,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vin_ok_a,
    input  logic             vin_ov_a,
    input  logic             lp_pin_a,
    input  logic             btn_n_a,
    input  logic             ocp_a,
    input  logic             bus_busy,
    input  logic             hwrst_start,
    input  logic             pwrup_done,
    input  logic [BAT_W-1:0] bat_code,
    input  logic [BAT_W-1:0] bat_thr,
    output logic [1:0]       mode_o,
    output logic             clk_en_o,
    output logic             bus_en_o,
    output logic             adc_en_o,
    output logic             dsg_en_o
);
    import pmic_mode_pkg::*;

    localparam int HYST_CODES = hyst_codes(HYST_MV, LSB_MV);

    pin_bus_t  pins_a;
    pin_bus_t  pins_s;
    logic      bat_ok;
    pwr_mode_e mode;
    pwr_en_t   en;

    assign pins_a = '{vin_ok: vin_ok_a, vin_ov: vin_ov_a, lp_pin: lp_pin_a,
                      btn_n: btn_n_a, ocp: ocp_a};

    pmic_sync #(
        .W       (PIN_COUNT),
        .STAGES  (SYNC_N),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_a (pins_a),
        .q   (pins_s)
    );

    pmic_bat_uv #(
        .W    (BAT_W),
        .HYST (HYST_CODES)
    ) u_bat_uv (
        .clk    (clk),
        .rst    (rst),
        .code   (bat_code),
        .thr    (bat_thr),
        .bat_ok (bat_ok)
    );

    pmic_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pins        (pins_s),
        .busy        (bus_busy),
        .hwrst_start (hwrst_start),
        .pwrup_done  (pwrup_done),
        .bat_ok      (bat_ok),
        .mode        (mode),
        .en          (en)
    );

    assign mode_o   = mode;
    assign clk_en_o = en.clk_en;
    assign bus_en_o = en.bus_en;
    assign adc_en_o = en.adc_en;
    assign dsg_en_o = en.dsg_en;
endmodule

// File: tb/pmic_mode_ctrl_tb_top.sv
module pmic_mode_ctrl_tb_top;
    localparam int BW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vin_ok_a = 0, vin_ov_a = 0, lp_pin_a = 1, btn_n_a = 1, ocp_a = 0;
    logic bus_busy = 0, hwrst_start = 0, pwrup_done = 0;
    logic [BW-1:0] bat_code = 10'd200;
    logic [BW-1:0] bat_thr  = 10'd100;
    logic [1:0] mode_o;
    logic clk_en_o, bus_en_o, adc_en_o, dsg_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct packed {
        logic [1:0] mode;
        logic       clk_en;
        logic       bus_en;
        logic       adc_en;
        logic       dsg_en;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #5 clk = ~clk;

    pmic_mode_ctrl dut_i (
        .clk (clk), .rst (rst),
        .vin_ok_a (vin_ok_a), .vin_ov_a (vin_ov_a), .lp_pin_a (lp_pin_a),
        .btn_n_a (btn_n_a), .ocp_a (ocp_a), .bus_busy (bus_busy),
        .hwrst_start (hwrst_start), .pwrup_done (pwrup_done),
        .bat_code (bat_code), .bat_thr (bat_thr),
        .mode_o (mode_o), .clk_en_o (clk_en_o), .bus_en_o (bus_en_o),
        .adc_en_o (adc_en_o), .dsg_en_o (dsg_en_o)
    );

    // expected outputs for a mode, per R3, R7, R9
    function automatic exp_t mk(input logic [1:0] m, input logic dsg);
        exp_t e;
        e.mode   = m;
        e.clk_en = (m != 2'b00);
        e.bus_en = (m != 2'b00);
        e.adc_en = (m == 2'b10);
        e.dsg_en = dsg;
        return e;
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_out(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // monitor: compares after the driver's falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{mode: mode_o, clk_en: clk_en_o, bus_en: bus_en_o,
                      adc_en: adc_en_o, dsg_en: dsg_en_o};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual mode=%b clk=%b bus=%b adc=%b dsg=%b expected mode=%b clk=%b bus=%b adc=%b dsg=%b",
                             t, a.mode, a.clk_en, a.bus_en, a.adc_en, a.dsg_en,
                             e.mode, e.clk_en, e.bus_en, e.adc_en, e.dsg_en);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still going, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(mk(2'b01, 1'b0), "R10 reset state");
        @(negedge clk);
        rst = 1'b0;
        settle();
        expect_out(mk(2'b01, 1'b1), "R10 active after reset, R7 switch on");

        lp_pin_a = 0; bus_busy = 1;
        settle();
        expect_out(mk(2'b01, 1'b1), "R1 busy blocks entry");
        bus_busy = 0;
        settle();
        expect_out(mk(2'b00, 1'b1), "R1 entry, R3 gated");
        bus_busy = 1;
        settle();
        expect_out(mk(2'b00, 1'b1), "R1 busy ignored once in low-power");
        bus_busy = 0;

        btn_n_a = 0;
        settle();
        expect_out(mk(2'b01, 1'b1), "R5 button held");
        btn_n_a = 1;
        settle();
        expect_out(mk(2'b00, 1'b1), "R5 button released");

        vin_ov_a = 1;
        settle();
        expect_out(mk(2'b01, 1'b1), "R4 overvoltage with LP pin low");
        vin_ok_a = 1;
        settle();
        expect_out(mk(2'b01, 1'b1), "R4 overvoltage beats charger");
        vin_ov_a = 0;
        settle();
        expect_out(mk(2'b10, 1'b0), "R9 charger, R2 exit");
        vin_ok_a = 0;
        settle();
        expect_out(mk(2'b00, 1'b1), "R1 back to low-power");

        lp_pin_a = 1;
        settle();
        expect_out(mk(2'b01, 1'b1), "R2 exit on pin high");
        lp_pin_a = 0;
        settle();
        expect_out(mk(2'b00, 1'b1), "R1 re-entry");

        btn_n_a = 0;
        settle();
        pulse(hwrst_start);
        btn_n_a = 1;
        settle();
        expect_out(mk(2'b01, 1'b1), "R6 hold after reset start");
        pulse(pwrup_done);
        settle();
        expect_out(mk(2'b00, 1'b1), "R6 released by power-up done");

        lp_pin_a = 1;
        settle();
        pulse(hwrst_start);
        lp_pin_a = 0;
        settle();
        expect_out(mk(2'b00, 1'b1), "R6 start with pin high ignored");

        lp_pin_a = 1;
        bat_code = 10'd99;
        settle();
        expect_out(mk(2'b01, 1'b0), "R8 below trip");
        bat_code = 10'd114;
        settle();
        expect_out(mk(2'b01, 1'b0), "R8 inside band stays off");
        bat_code = 10'd115;
        settle();
        expect_out(mk(2'b01, 1'b1), "R8 at rise level");
        bat_code = 10'd100;
        settle();
        expect_out(mk(2'b01, 1'b1), "R8 at trip level stays on");
        bat_code = 10'd99;
        settle();
        expect_out(mk(2'b01, 1'b0), "R7 off below threshold");
        bat_code = 10'd200;
        settle();
        ocp_a = 1;
        settle();
        expect_out(mk(2'b01, 1'b0), "R7 overcurrent off");
        ocp_a = 0;
        settle();
        expect_out(mk(2'b01, 1'b1), "R7 overcurrent cleared");

        settle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule